// File: doc/BRIEF.md
# Circuit-Switched Router Control Unit

This block is the synchronous control half of one router in a two-dimensional mesh circuit-switched network. Control flits arrive on five input channels: north, east, south, west and a local channel for the attached core. Each flit either sets up or tears down an end-to-end path. The unit chooses an output for each flit by dimension-order routing, X first and then Y. A round-robin arbiter on every output picks among competing requests. The winning flit is forwarded to the next router, and the unit records which input now owns that output.

An owned output is first held in a reserved state. It becomes active only when the next router returns an acknowledgement, and that acknowledgement is then passed back to the owning input. While any output is active, the unit raises the enable for the data switch and keeps that output's crossbar select steady. A release flit from the owner is forwarded downstream, clears the select and frees the output. The router's own mesh coordinates are plain input pins, so one design serves every mesh position.

Flit channels use valid/ready. A flit moves on a cycle where both valid and ready are high. An input holds its flit and keeps valid asserted until ready is seen. A forwarded flit stays on its output channel, unchanged, until that channel's ready is high, and no new flit is granted to that output while it waits. Acknowledgement pins carry single-cycle pulses.

Top module: `ccu_router_ctrl`

## Requirements
- R1: Flit layout, width 9 with 2-bit coordinates, bit 8 down to bit 0: op (1 = reserve, 0 = release), destination x [7:6], destination y [5:4], source x [3:2], source y [1:0]. Port indices are north 0, east 1, south 2, west 3, local 4. The output is east if destination x > node x, west if it is smaller. When x matches, the output is south if destination y > node y and north if it is smaller. When both match, the output is local.
- R2: A reserve flit reaching an idle output is accepted in the same cycle (in_ready high). On the next cycle it appears on that output's channel, and that output's 5-bit one-hot select holds the bit of the granted input.
- R3: Requests for one output are granted round-robin. After reset the search starts at input 0. After each grant it starts just past the last winner.
- R4: A reserve flit aimed at an output that is reserved or active is not accepted. It waits, and it is granted once that output has been released.
- R5: A down_ack pulse on an output in the reserved state makes it active. One cycle later it gives a single-cycle up_ack pulse on the owning input. A down_ack on an idle output has no effect.
- R6: A release flit from the owner of an active output is accepted and forwarded downstream. On the next cycle that output's select reads zero and the output is idle.
- R7: A release flit from an input that does not own its target output is consumed. It is not forwarded, and it changes no select and not the enable.
- R8: The select of an active output does not change until that output is released.
- R9: data_en is high exactly while at least one output is active.
- R10: Reset, active low, returns every output to idle. It clears all selects, out_valid, up_ack and data_en.
- R11: A forwarded flit whose channel sees ready low stays valid and unchanged. It is removed on the cycle after ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_x | input | 2 | This router's mesh column |
| node_y | input | 2 | This router's mesh row |
| in_valid | input | 5 | Flit present on each input channel |
| in_ready | output | 5 | Input flit taken this cycle |
| in_flit | input | 5x9 | Flit on each input channel |
| out_valid | output | 5 | Forwarded flit present on each output channel |
| out_ready | input | 5 | Downstream takes the forwarded flit |
| out_flit | output | 5x9 | Forwarded flit on each output channel |
| down_ack | input | 5 | Reservation confirmed by the next router, per output |
| up_ack | output | 5 | Reservation confirmation sent back, per input |
| xbar_sel | output | 5x5 | One-hot source input chosen for each output of the data switch |
| data_en | output | 1 | Data switch enable |

## Verification
Routing is tried from a table of node and destination pairs. The pairs cover all four directions, the local case, and corners where both coordinates differ, which tells X-first order apart from Y-first. Directed sequences run a full reserve, acknowledge and release cycle on one output. Alongside it they send a competing reserve, a stray release and an acknowledgement on an idle output. These separate holding, dropping and ignoring. Three inputs contend repeatedly for one output, including one that requests again right after releasing. This tells a rotating priority apart from a fixed one. A stalled output channel and a reset in the middle of a transfer cover back-pressure and the return to idle.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  parameter int unsigned NPORT = 5;
  parameter int unsigned CW    = 2;
  localparam int unsigned FLIT_W = 1 + 4 * CW;

  localparam int unsigned P_NORTH = 0;
  localparam int unsigned P_EAST  = 1;
  localparam int unsigned P_SOUTH = 2;
  localparam int unsigned P_WEST  = 3;
  localparam int unsigned P_LOCAL = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_RSVD, ST_ACTV} pstate_e;

  typedef struct packed {
    logic          rsv;
    logic [CW-1:0] dx;
    logic [CW-1:0] dy;
    logic [CW-1:0] sx;
    logic [CW-1:0] sy;
  } flit_t;
endpackage

// File: rtl/ccu_xy_route.sv
module ccu_xy_route
  import ccu_pkg::*;
(
  input  logic [CW-1:0]    here_x,
  input  logic [CW-1:0]    here_y,
  input  logic [CW-1:0]    dst_x,
  input  logic [CW-1:0]    dst_y,
  output logic [NPORT-1:0] dir
);
  always_comb begin
    dir = '0;
    if (dst_x > here_x)      dir[P_EAST]  = 1'b1;
    else if (dst_x < here_x) dir[P_WEST]  = 1'b1;
    else if (dst_y > here_y) dir[P_SOUTH] = 1'b1;
    else if (dst_y < here_y) dir[P_NORTH] = 1'b1;
    else                     dir[P_LOCAL] = 1'b1;
  end
endmodule

// File: rtl/ccu_rr_arb.sv
module ccu_rr_arb #(
  parameter int unsigned N = 5,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] win;

  always_comb begin
    gnt = '0;
    win = last_q;
    for (int k = 1; k <= int'(N); k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= int'(N)) idx = idx - int'(N);
      if (req[idx] && gnt == '0) begin
        gnt[idx] = 1'b1;
        win      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IW'(N - 1);
    else if (|gnt) last_q <= win;
  end
endmodule

// File: rtl/ccu_out_port.sv
module ccu_out_port
  import ccu_pkg::*;
#(
  parameter int unsigned NP = NPORT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP-1:0]   rsv_req,
  input  logic [NP-1:0]   rel_req,
  input  flit_t [NP-1:0]  flits,
  input  logic            down_ack,
  input  logic            out_ready,
  output logic [NP-1:0]   grant,
  output logic            out_valid,
  output flit_t           out_flit,
  output logic [NP-1:0]   sel,
  output logic            is_active,
  output logic            is_busy,
  output logic [NP-1:0]   ack_up
);
  pstate_e       st_q;
  logic          slot_free;
  logic [NP-1:0] arb_req;
  flit_t         pick;

  always_comb begin
    slot_free = !out_valid || out_ready;
    arb_req   = '0;
    if (slot_free) begin
      unique case (st_q)
        ST_IDLE: arb_req = rsv_req;
        ST_ACTV: arb_req = rel_req & sel;
        default: arb_req = '0;
      endcase
    end
  end

  ccu_rr_arb #(.N(NP)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (arb_req),
    .gnt  (grant)
  );

  always_comb begin
    pick = flit_t'('0);
    for (int i = 0; i < int'(NP); i++)
      if (grant[i]) pick = flits[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sel       <= '0;
      out_valid <= 1'b0;
      out_flit  <= flit_t'('0);
      ack_up    <= '0;
    end else begin
      ack_up <= '0;
      if (|grant) begin
        out_valid <= 1'b1;
        out_flit  <= pick;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      unique case (st_q)
        ST_IDLE: if (|grant) begin
          st_q <= ST_RSVD;
          sel  <= grant;
        end
        ST_RSVD: if (down_ack) begin
          st_q   <= ST_ACTV;
          ack_up <= sel;
        end
        ST_ACTV: if (|grant) begin
          st_q <= ST_IDLE;
          sel  <= '0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign is_active = (st_q == ST_ACTV);
  assign is_busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/ccu_router_ctrl.sv
module ccu_router_ctrl
  import ccu_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [CW-1:0]                node_x,
  input  logic [CW-1:0]                node_y,
  input  logic [NPORT-1:0]             in_valid,
  output logic [NPORT-1:0]             in_ready,
  input  logic [NPORT-1:0][FLIT_W-1:0] in_flit,
  output logic [NPORT-1:0]             out_valid,
  input  logic [NPORT-1:0]             out_ready,
  output logic [NPORT-1:0][FLIT_W-1:0] out_flit,
  input  logic [NPORT-1:0]             down_ack,
  output logic [NPORT-1:0]             up_ack,
  output logic [NPORT-1:0][NPORT-1:0]  xbar_sel,
  output logic                         data_en
);
  flit_t [NPORT-1:0]             flit_v;
  flit_t [NPORT-1:0]             oflit;
  logic  [NPORT-1:0][NPORT-1:0]  dir;      // [input][output]
  logic  [NPORT-1:0][NPORT-1:0]  rsv_m;    // [output][input]
  logic  [NPORT-1:0][NPORT-1:0]  rel_m;
  logic  [NPORT-1:0][NPORT-1:0]  gnt_m;
  logic  [NPORT-1:0][NPORT-1:0]  ack_m;
  logic  [NPORT-1:0]             actv;
  logic  [NPORT-1:0]             busy;

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assign flit_v[i] = flit_t'(in_flit[i]);
    ccu_xy_route u_rt (
      .here_x(node_x),
      .here_y(node_y),
      .dst_x (flit_v[i].dx),
      .dst_y (flit_v[i].dy),
      .dir   (dir[i])
    );
  end

  always_comb begin
    for (int o = 0; o < int'(NPORT); o++)
      for (int i = 0; i < int'(NPORT); i++) begin
        rsv_m[o][i] = in_valid[i] &  flit_v[i].rsv & dir[i][o];
        rel_m[o][i] = in_valid[i] & ~flit_v[i].rsv & dir[i][o];
      end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    ccu_out_port #(.NP(NPORT)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .rsv_req  (rsv_m[o]),
      .rel_req  (rel_m[o]),
      .flits    (flit_v),
      .down_ack (down_ack[o]),
      .out_ready(out_ready[o]),
      .grant    (gnt_m[o]),
      .out_valid(out_valid[o]),
      .out_flit (oflit[o]),
      .sel      (xbar_sel[o]),
      .is_active(actv[o]),
      .is_busy  (busy[o]),
      .ack_up   (ack_m[o])
    );
    assign out_flit[o] = oflit[o];
  end

  // A release is held only when it comes from the owner of a busy output;
  // any other release is consumed without effect.
  always_comb begin
    for (int i = 0; i < int'(NPORT); i++) begin
      logic rdy, ack, held;
      rdy  = 1'b0;
      ack  = 1'b0;
      held = 1'b0;
      for (int o = 0; o < int'(NPORT); o++) begin
        rdy  = rdy  | gnt_m[o][i];
        ack  = ack  | ack_m[o][i];
        held = held | (dir[i][o] & busy[o] & xbar_sel[o][i]);
      end
      in_ready[i] = rdy | (in_valid[i] & ~flit_v[i].rsv & ~held);
      up_ack[i]   = ack;
    end
  end

  assign data_en = |actv;
endmodule

// File: rtl/ccu_router_ctrl_chk.sv
module ccu_router_ctrl_chk
  import ccu_pkg::*;
(
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORT-1:0]             out_valid,
  input logic [NPORT-1:0]             out_ready,
  input logic [NPORT-1:0][FLIT_W-1:0] out_flit,
  input logic [NPORT-1:0]             down_ack,
  input logic [NPORT-1:0]             up_ack,
  input logic [NPORT-1:0][NPORT-1:0]  xbar_sel,
  input logic                         data_en,
  input logic [NPORT-1:0]             actv
);
  for (genvar o = 0; o < NPORT; o++) begin : g_chk
    p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xbar_sel[o]));

    p_sel_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      actv[o] |=> (!actv[o] || $stable(xbar_sel[o])));

    p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_flit[o])));

    p_active_has_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      actv[o] |-> (xbar_sel[o] != '0));
  end

  p_en_needs_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    data_en |-> (xbar_sel != '0));

  p_upack_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ack != '0) |-> $past(down_ack != '0));
endmodule

bind ccu_router_ctrl ccu_router_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_flit (out_flit),
  .down_ack (down_ack),
  .up_ack   (up_ack),
  .xbar_sel (xbar_sel),
  .data_en  (data_en),
  .actv     (actv)
);

// File: tb/ccu_router_ctrl_bench.sv
`timescale 1ns/1ps
module ccu_router_ctrl_bench;
  import ccu_pkg::*;

  logic clk = 1'b0;
  logic rst_n;
  logic [CW-1:0] node_x, node_y;
  logic [NPORT-1:0] in_valid, in_ready, out_valid, out_ready, down_ack, up_ack;
  logic [NPORT-1:0][FLIT_W-1:0] in_flit, out_flit;
  logic [NPORT-1:0][NPORT-1:0] xbar_sel;
  logic data_en;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ccu_router_ctrl u_ccu_router_ctrl (
    .clk(clk), .rst_n(rst_n), .node_x(node_x), .node_y(node_y),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .down_ack(down_ack), .up_ack(up_ack), .xbar_sel(xbar_sel), .data_en(data_en)
  );

  function automatic logic [FLIT_W-1:0] mk(input logic rsv, input int dx, input int dy,
                                           input int sx, input int sy);
    return {rsv, CW'(dx), CW'(dy), CW'(sx), CW'(sy)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0; in_flit = '0; out_ready = '1; down_ack = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // {here_x, here_y, dst_x, dst_y, expected output}
  localparam int NVEC = 10;
  localparam logic [10:0] VEC [NVEC] = '{
    {2'd1, 2'd1, 2'd3, 2'd1, 3'd1},
    {2'd2, 2'd2, 2'd0, 2'd2, 3'd3},
    {2'd1, 2'd1, 2'd1, 2'd3, 3'd2},
    {2'd2, 2'd2, 2'd2, 2'd0, 3'd0},
    {2'd1, 2'd2, 2'd1, 2'd2, 3'd4},
    {2'd0, 2'd0, 2'd3, 2'd3, 3'd1},
    {2'd3, 2'd0, 2'd0, 2'd3, 3'd3},
    {2'd0, 2'd3, 2'd0, 2'd0, 3'd0},
    {2'd3, 2'd3, 2'd3, 2'd3, 3'd4},
    {2'd2, 2'd1, 2'd3, 2'd0, 3'd1}
  };

  localparam logic [FLIT_W-1:0] RSV_E_L = 9'h1D1 ^ 9'h1D1 | {1'b1, 2'd3, 2'd1, 2'd1, 2'd1};

  task automatic rr_round(input int w);
    logic [FLIT_W-1:0] rsv_f, rel_f;
    rsv_f = mk(1'b1, 3, 1, 1, 1);
    rel_f = mk(1'b0, 3, 1, 1, 1);
    #1 chk(in_ready == 5'(1 << w), "R3 round-robin winner", in_ready, 5'(1 << w));
    @(negedge clk);
    in_flit[w] = rel_f;
    down_ack[1] = 1'b1;
    #1 chk(xbar_sel[1] == 5'(1 << w), "R3 select follows winner", xbar_sel[1], 5'(1 << w));
    @(negedge clk);
    down_ack[1] = 1'b0;
    #1 chk(in_ready == 5'(1 << w), "R6 owner release accepted", in_ready, 5'(1 << w));
    @(negedge clk);
    in_flit[w] = rsv_f;
  endtask

  initial begin
    logic [FLIT_W-1:0] f, held_f;
    rst_n = 1'b0; node_x = '0; node_y = '0;
    in_valid = '0; in_flit = '0; out_ready = '1; down_ack = '0;

    // R10: reset state
    do_reset();
    #1;
    chk(out_valid == '0, "R10 out_valid after reset", out_valid, 0);
    chk(xbar_sel == '0, "R10 selects after reset", xbar_sel, 0);
    chk(data_en == 1'b0 && up_ack == '0, "R10 enable/ack after reset", {data_en, up_ack}, 0);

    // R1: routing table, reserve sent from the local input
    for (int v = 0; v < NVEC; v++) begin
      int e;
      do_reset();
      node_x = VEC[v][10:9];
      node_y = VEC[v][8:7];
      e = int'(VEC[v][2:0]);
      f = mk(1'b1, int'(VEC[v][6:5]), int'(VEC[v][4:3]), int'(VEC[v][10:9]), int'(VEC[v][8:7]));
      in_valid[4] = 1'b1; in_flit[4] = f;
      @(negedge clk);
      in_valid[4] = 1'b0;
      #1;
      chk(out_valid == 5'(1 << e), "R1 routed output", out_valid, 5'(1 << e));
      chk(out_flit[e] == f && xbar_sel[e] == 5'b10000, "R1 R2 forwarded flit and select",
          {out_flit[e], xbar_sel[e]}, {f, 5'b10000});
    end

    // Directed: reserve, ack, hold, stray release, owner release
    do_reset();
    node_x = 2'd1; node_y = 2'd1;
    f = mk(1'b1, 3, 1, 1, 1);
    in_valid[4] = 1'b1; in_flit[4] = f;
    #1 chk(in_ready == 5'b10000, "R2 reserve accepted", in_ready, 5'b10000);
    @(negedge clk);
    in_valid[4] = 1'b0;
    #1;
    chk(out_valid == 5'b00010 && out_flit[1] == f, "R2 reserve forwarded east", out_valid, 5'b00010);
    chk(xbar_sel[1] == 5'b10000, "R2 select set", xbar_sel[1], 5'b10000);
    chk(data_en == 1'b0, "R9 no enable while only reserved", data_en, 0);
    @(negedge clk);
    #1 chk(out_valid == '0, "R11 flit removed once taken", out_valid, 0);
    down_ack[0] = 1'b1;
    @(negedge clk);
    down_ack[0] = 1'b0;
    #1 chk(up_ack == '0 && xbar_sel[0] == '0 && data_en == 1'b0, "R5 ack on idle output ignored",
           {up_ack, xbar_sel[0], data_en}, 0);
    down_ack[1] = 1'b1;
    @(negedge clk);
    down_ack[1] = 1'b0;
    #1;
    chk(up_ack == 5'b10000, "R5 ack returned to owner", up_ack, 5'b10000);
    chk(data_en == 1'b1, "R9 enable when active", data_en, 1);
    @(negedge clk);
    #1 chk(up_ack == '0, "R5 ack is one cycle", up_ack, 0);
    held_f = mk(1'b1, 3, 1, 1, 0);
    in_valid[0] = 1'b1; in_flit[0] = held_f;
    #1 chk(in_ready == '0, "R4 reserve to active output held", in_ready, 0);
    @(negedge clk);
    #1 chk(in_ready == '0 && out_valid == '0 && xbar_sel[1] == 5'b10000,
           "R4 R8 still held, select frozen", {in_ready, xbar_sel[1]}, {5'b0, 5'b10000});
    in_valid[2] = 1'b1; in_flit[2] = mk(1'b0, 3, 1, 1, 2);
    #1 chk(in_ready[2] == 1'b1, "R7 stray release consumed", in_ready[2], 1);
    @(negedge clk);
    in_valid[2] = 1'b0;
    #1 chk(out_valid == '0 && xbar_sel[1] == 5'b10000 && data_en == 1'b1,
           "R7 stray release had no effect", {out_valid, xbar_sel[1], data_en}, {5'b0, 5'b10000, 1'b1});
    f = mk(1'b0, 3, 1, 1, 1);
    in_valid[4] = 1'b1; in_flit[4] = f;
    #1 chk(in_ready == 5'b10000, "R6 owner release accepted", in_ready, 5'b10000);
    @(negedge clk);
    in_valid[4] = 1'b0;
    #1;
    chk(out_valid == 5'b00010 && out_flit[1] == f, "R6 release forwarded", out_flit[1], f);
    chk(xbar_sel[1] == '0 && data_en == 1'b0, "R6 R9 select cleared, enable low",
        {xbar_sel[1], data_en}, 0);
    chk(in_ready[0] == 1'b1, "R4 waiting reserve now granted", in_ready[0], 1);
    @(negedge clk);
    in_valid[0] = 1'b0;
    #1 chk(xbar_sel[1] == 5'b00001 && out_flit[1] == held_f, "R4 waiting reserve forwarded",
           xbar_sel[1], 5'b00001);

    // R11: back-pressure on the east channel, then R10 reset mid-transfer
    do_reset();
    node_x = 2'd1; node_y = 2'd1;
    out_ready[1] = 1'b0;
    f = mk(1'b1, 3, 1, 1, 1);
    in_valid[4] = 1'b1; in_flit[4] = f;
    @(negedge clk);
    in_valid[4] = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1 chk(out_valid[1] == 1'b1 && out_flit[1] == f, "R11 flit held under back-pressure",
             out_flit[1], f);
    end
    out_ready[1] = 1'b1;
    @(negedge clk);
    #1 chk(out_valid[1] == 1'b0, "R11 flit removed after ready", out_valid[1], 0);
    down_ack[1] = 1'b1;
    @(negedge clk);
    down_ack[1] = 1'b0;
    #1 chk(data_en == 1'b1, "R9 active after ack", data_en, 1);
    rst_n = 1'b0;
    @(negedge clk);
    #1 chk(data_en == 1'b0 && xbar_sel == '0 && out_valid == '0, "R10 reset during transfer",
           {data_en, out_valid}, 0);
    rst_n = 1'b1;

    // R3: three inputs contend for east, winner re-requests after release
    do_reset();
    node_x = 2'd1; node_y = 2'd1;
    f = mk(1'b1, 3, 1, 1, 1);
    in_valid[0] = 1'b1; in_flit[0] = f;
    in_valid[2] = 1'b1; in_flit[2] = f;
    in_valid[4] = 1'b1; in_flit[4] = f;
    rr_round(0);
    rr_round(2);
    rr_round(4);
    rr_round(0);
    in_valid = '0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule